// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This unit carries out the three register-operand control/status register instructions (swap, bit-set and bit-clear) against a small local bank of registers. Each request supplies a 12-bit register address, a source operand, an operation code, a flag telling whether the source register index is non-zero, and the privilege level of the requester. A request is taken on any clock edge where `req_valid` is high. One cycle later the unit presents the register's value as it was before the access, and it commits the new value on that same edge.

All three operations share a single masked-merge primitive: `new = (old & ~mask) | (value & mask)`. The operation only chooses the value and the mask. Swap writes the operand under an all-ones mask. Set writes all-ones under the operand as mask. Clear writes all-zeros under the operand as mask. The mask for set and clear is forced to zero when the source index is zero, so those forms become pure reads.

The legality check looks at several things: the address must hit an implemented register, the requester must hold enough privilege, the operation code must be valid, and a read-only register must not be written. An access that fails the check reports an illegal-instruction flag, returns zero and changes no state.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset `rsp_valid` is 0. The registers hold their reset values: 0 at addresses 0x040, 0x140, 0x340 and 0x344, and `ID_VALUE` at 0xF12.
- R2: Operation code 2'b01 (swap) replaces every writable bit of the addressed register with `req_src`. This happens whatever the value of `req_src_nz`.
- R3: Operation code 2'b10 (set) ORs `req_src` into the register when `req_src_nz`=1. When `req_src_nz`=0 the register is left unchanged.
- R4: Operation code 2'b11 (clear) clears the bits set in `req_src` when `req_src_nz`=1. When `req_src_nz`=0 the register is left unchanged.
- R5: `req_ready` is always 1. A request taken at a clock edge gives `rsp_valid`=1 after that edge, with `rsp_rdata` equal to the register value from before the write. Back-to-back requests each get their own response, and the second one sees the first one's write.
- R6: An address that matches no implemented register gives `rsp_illegal`=1 and `rsp_rdata`=0, and no register changes.
- R7: Address bits [9:8] give the lowest privilege allowed to access the register (0=user, 1=supervisor, 3=machine). A request whose `req_priv` is numerically lower is illegal and has no effect.
- R8: Address bits [11:10]=2'b11 mark a register as read-only. A swap to such a register is always illegal. A set or clear to it is illegal only when the effective mask is non-zero (`req_src_nz`=1 and `req_src`≠0); otherwise it is a legal read. The register's value never changes.
- R9: Only the bits in `CTRL_WMASK` of register 0x344 can be written. Its other bits always read 0.
- R10: Operation code 2'b00 is illegal and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request (always 1) |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| req_op | input | 2 | 01 swap, 10 set, 11 clear, 00 invalid |
| req_src_nz | input | 1 | Source register index is non-zero |
| req_priv | input | 2 | Requester privilege level |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | XLEN | Old register value (0 when illegal) |
| rsp_illegal | output | 1 | Access rejected as illegal instruction |

## Verification
The bench checks set and clear with the zero-index flag clear, even when the operand is all-ones. A design that took the mask straight from the operand would corrupt the register. The read-only register is the main target:
- a set with zero effective mask must be accepted;
- a clear with a non-zero mask, or any swap, must be rejected.

A design that keyed legality on the operation alone, instead of on the effective mask, fails one of these three cases.

Back-to-back requests catch a read-back taken after the commit instead of before it. Privilege checks cover the exact boundary, where a supervisor may access a supervisor register but not a machine one. The write-masked control register catches a merge that ignores that register's writable-bit mask.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    CSR_OP_NONE = 2'b00,
    CSR_OP_SWAP = 2'b01,
    CSR_OP_SET  = 2'b10,
    CSR_OP_CLR  = 2'b11
  } csr_op_e;

  localparam int CSR_AW  = 12;
  localparam int CSR_NREG = 5;

  // register index map: 0 user scratch, 1 supervisor scratch,
  // 2 machine scratch, 3 machine control (write-masked), 4 machine id (read-only)
  function automatic logic [CSR_AW-1:0] reg_addr(input int idx);
    case (idx)
      0:       return 12'h040;
      1:       return 12'h140;
      2:       return 12'h340;
      3:       return 12'h344;
      default: return 12'hF12;
    endcase
  endfunction

  function automatic logic addr_is_ro(input logic [CSR_AW-1:0] a);
    return a[11:10] == 2'b11;
  endfunction

  function automatic logic [1:0] addr_min_priv(input logic [CSR_AW-1:0] a);
    return a[9:8];
  endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_rmw_pkg::*;
#(
  parameter int NREG = CSR_NREG
) (
  input  logic [CSR_AW-1:0] addr,
  input  logic [1:0]        cur_priv,
  output logic [NREG-1:0]   sel,
  output logic              hit,
  output logic              ro,
  output logic              priv_ok
);

  for (genvar i = 0; i < NREG; i++) begin : g_match
    assign sel[i] = (addr == reg_addr(i));
  end

  assign hit     = |sel;
  assign ro      = addr_is_ro(addr);
  assign priv_ok = (cur_priv >= addr_min_priv(addr));

endmodule

// File: rtl/csr_wgen.sv
module csr_wgen
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic            src_nz,
  output logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] wmask,
  output logic            op_ok
);

  function automatic logic [XLEN-1:0] gen_value(input csr_op_e o, input logic [XLEN-1:0] s);
    case (o)
      CSR_OP_SWAP: return s;
      CSR_OP_SET:  return '1;
      default:     return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] gen_mask(input csr_op_e o, input logic [XLEN-1:0] s,
                                               input logic nz);
    case (o)
      CSR_OP_SWAP: return '1;
      CSR_OP_SET,
      CSR_OP_CLR:  return nz ? s : '0;
      default:     return '0;
    endcase
  endfunction

  csr_op_e op_e;
  assign op_e  = csr_op_e'(op);
  assign wval  = gen_value(op_e, src);
  assign wmask = gen_mask(op_e, src, src_nz);
  assign op_ok = (op_e != CSR_OP_NONE);

endmodule

// File: rtl/csr_reg_cell.sv
module csr_reg_cell #(
  parameter int              XLEN  = 32,
  parameter logic [XLEN-1:0] RST   = '0,
  parameter logic [XLEN-1:0] WMASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] wval,
  input  logic [XLEN-1:0] wmask,
  output logic [XLEN-1:0] q
);

  function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] old_v,
                                            input logic [XLEN-1:0] new_v,
                                            input logic [XLEN-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  logic [XLEN-1:0] eff_mask;
  assign eff_mask = wmask & WMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= merge(q, wval, eff_mask);
  end

  // R9: bits outside the writable mask never leave their reset value
  a_r9_locked_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~WMASK) == (RST & ~WMASK));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] ID_VALUE   = 32'h5A17_0C01,
  parameter logic [XLEN-1:0] CTRL_WMASK = 32'h0000_0F0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CSR_AW-1:0] req_addr,
  input  logic [XLEN-1:0]   req_src,
  input  logic [1:0]        req_op,
  input  logic              req_src_nz,
  input  logic [1:0]        req_priv,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              rsp_illegal
);

  localparam int NREG   = CSR_NREG;
  localparam int ID_IDX = NREG - 1;

  function automatic logic [XLEN-1:0] rst_of(input int idx);
    return (idx == ID_IDX) ? ID_VALUE : '0;
  endfunction

  function automatic logic [XLEN-1:0] wmask_of(input int idx);
    case (idx)
      3:       return CTRL_WMASK;
      ID_IDX:  return '0;
      default: return '1;
    endcase
  endfunction

  // decode and write generation
  logic [NREG-1:0] sel;
  logic            hit, ro, priv_ok, op_ok;
  logic [XLEN-1:0] wval, wmask;

  csr_addr_decode #(.NREG(NREG)) u_dec (
    .addr(req_addr), .cur_priv(req_priv),
    .sel(sel), .hit(hit), .ro(ro), .priv_ok(priv_ok)
  );

  csr_wgen #(.XLEN(XLEN)) u_wgen (
    .op(req_op), .src(req_src), .src_nz(req_src_nz),
    .wval(wval), .wmask(wmask), .op_ok(op_ok)
  );

  // named events
  logic acc, mask_nz, illegal_now, wr_fire;
  assign req_ready   = 1'b1;
  assign acc         = req_valid && req_ready;
  assign mask_nz     = |wmask;
  assign illegal_now = !op_ok || !hit || !priv_ok || (ro && mask_nz);
  assign wr_fire     = acc && !illegal_now && mask_nz;

  // register bank
  logic [NREG-1:0][XLEN-1:0] rq;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    csr_reg_cell #(.XLEN(XLEN), .RST(rst_of(i)), .WMASK(wmask_of(i))) u_cell (
      .clk(clk), .rst_n(rst_n), .we(wr_fire && sel[i]),
      .wval(wval), .wmask(wmask), .q(rq[i])
    );
  end

  // old-value readback
  logic [XLEN-1:0] old_val;
  always_comb begin
    old_val = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) old_val = old_val | rq[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_illegal <= illegal_now;
        rsp_rdata   <= illegal_now ? '0 : old_val;
      end
    end
  end

  // assertions
  a_r5_rsp_follows_acc: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && illegal_now) |=> $stable(rq));
  a_r6_illegal_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (rsp_rdata == '0));
  a_r3_zero_mask_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mask_nz) |=> $stable(rq));
  a_r8_ro_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rq[ID_IDX] == ID_VALUE);
  a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  a_r7_low_priv_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_priv < req_addr[9:8])) |=> rsp_illegal);

endmodule

// File: tb/sim_csr_rmw_unit.sv
module sim_csr_rmw_unit;

  localparam logic [31:0] IDV = 32'h5A17_0C01;
  localparam logic [31:0] CWM = 32'h0000_0F0F;
  localparam logic [1:0] P_U = 2'd0, P_S = 2'd1, P_M = 2'd3;
  localparam logic [1:0] O_NONE = 2'b00, O_SWAP = 2'b01, O_SET = 2'b10, O_CLR = 2'b11;
  localparam logic [11:0] A_U = 12'h040, A_S = 12'h140, A_M = 12'h340,
                          A_C = 12'h344, A_ID = 12'hF12, A_BAD = 12'h7C0;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [11:0] req_addr = '0;
  logic [31:0] req_src = '0;
  logic [1:0] req_op = '0, req_priv = '0;
  logic req_src_nz = 0;
  logic rsp_valid, rsp_illegal;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0;
  logic done = 0;

  always #5 clk = ~clk;

  csr_rmw_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_src(req_src), .req_op(req_op),
    .req_src_nz(req_src_nz), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] a, input logic [31:0] s, input logic [1:0] o,
                       input logic nz, input logic [1:0] p);
    req_valid = 1; req_addr = a; req_src = s; req_op = o; req_src_nz = nz; req_priv = p;
  endtask

  // one request, response captured on the following falling edge
  task automatic xfer(input logic [11:0] a, input logic [31:0] s, input logic [1:0] o,
                      input logic nz, input logic [1:0] p,
                      output logic ill, output logic [31:0] rd);
    @(negedge clk);
    drive(a, s, o, nz, p);
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (rsp_valid !== 1'b1) begin
      fails++;
      $display("FAIL R5 rsp_valid actual=%b expected=1", rsp_valid);
    end
    ill = rsp_illegal; rd = rsp_rdata;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
    logic ill;
    xfer(a, 32'hFFFF_FFFF, O_SET, 1'b0, P_M, ill, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R5 req_ready", {31'd0, req_ready}, 32'd1);
    rd_reg(A_U, v);  chk("R1 user scratch", v, 32'd0);
    rd_reg(A_S, v);  chk("R1 sup scratch", v, 32'd0);
    rd_reg(A_M, v);  chk("R1 mach scratch", v, 32'd0);
    rd_reg(A_C, v);  chk("R1 ctrl", v, 32'd0);
    rd_reg(A_ID, v); chk("R1 id", v, IDV);
  endtask

  task automatic t_swap;
    logic ill; logic [31:0] v;
    xfer(A_M, 32'hDEAD_BEEF, O_SWAP, 1'b1, P_M, ill, v);
    chk("R2 legal", {31'd0, ill}, 32'd0);
    chk("R2 old", v, 32'd0);
    xfer(A_M, 32'h1234_5678, O_SWAP, 1'b0, P_M, ill, v);
    chk("R2 old after first swap", v, 32'hDEAD_BEEF);
    rd_reg(A_M, v); chk("R2 swap with zero index", v, 32'h1234_5678);
  endtask

  task automatic t_set;
    logic ill; logic [31:0] v;
    xfer(A_U, 32'h0000_00F0, O_SET, 1'b1, P_U, ill, v);
    chk("R3 old", v, 32'd0);
    xfer(A_U, 32'h0F00_0000, O_SET, 1'b1, P_U, ill, v);
    chk("R3 old after set", v, 32'h0000_00F0);
    xfer(A_U, 32'hFFFF_FFFF, O_SET, 1'b0, P_U, ill, v);
    chk("R3 zero index legal", {31'd0, ill}, 32'd0);
    rd_reg(A_U, v); chk("R3 zero index no write", v, 32'h0F00_00F0);
  endtask

  task automatic t_clr;
    logic ill; logic [31:0] v;
    xfer(A_U, 32'h0000_0030, O_CLR, 1'b1, P_U, ill, v);
    chk("R4 old", v, 32'h0F00_00F0);
    xfer(A_U, 32'hFFFF_FFFF, O_CLR, 1'b0, P_U, ill, v);
    chk("R4 zero index legal", {31'd0, ill}, 32'd0);
    rd_reg(A_U, v); chk("R4 clear result", v, 32'h0F00_00C0);
  endtask

  task automatic t_back2back;
    @(negedge clk);
    drive(A_S, 32'hA5A5_0000, O_SWAP, 1'b1, P_S);
    @(negedge clk);
    chk("R5 first old", rsp_rdata, 32'd0);
    chk("R5 first valid", {31'd0, rsp_valid}, 32'd1);
    drive(A_S, 32'h0000_0001, O_SET, 1'b1, P_S);
    @(negedge clk);
    req_valid = 0;
    chk("R5 second old", rsp_rdata, 32'hA5A5_0000);
    chk("R5 second valid", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    chk("R5 idle no rsp", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_bad_addr;
    logic ill; logic [31:0] v;
    xfer(A_BAD, 32'hFFFF_FFFF, O_SWAP, 1'b1, P_M, ill, v);
    chk("R6 illegal", {31'd0, ill}, 32'd1);
    chk("R6 zero data", v, 32'd0);
    xfer(12'h341, 32'hFFFF_FFFF, O_SWAP, 1'b1, P_M, ill, v);
    chk("R6 near miss illegal", {31'd0, ill}, 32'd1);
    rd_reg(A_M, v); chk("R6 no change", v, 32'h1234_5678);
  endtask

  task automatic t_priv;
    logic ill; logic [31:0] v;
    xfer(A_S, 32'hFFFF_FFFF, O_SWAP, 1'b1, P_U, ill, v);
    chk("R7 user to sup illegal", {31'd0, ill}, 32'd1);
    xfer(A_M, 32'hFFFF_FFFF, O_SWAP, 1'b1, P_S, ill, v);
    chk("R7 sup to mach illegal", {31'd0, ill}, 32'd1);
    xfer(A_S, 32'h0, O_SET, 1'b0, P_S, ill, v);
    chk("R7 sup to sup legal", {31'd0, ill}, 32'd0);
    chk("R7 sup read value", v, 32'hA5A5_0001);
    rd_reg(A_M, v); chk("R7 mach unchanged", v, 32'h1234_5678);
  endtask

  task automatic t_ro;
    logic ill; logic [31:0] v;
    xfer(A_ID, 32'h0, O_SWAP, 1'b0, P_M, ill, v);
    chk("R8 swap illegal", {31'd0, ill}, 32'd1);
    xfer(A_ID, 32'hFFFF_FFFF, O_SET, 1'b0, P_M, ill, v);
    chk("R8 set zero index legal", {31'd0, ill}, 32'd0);
    chk("R8 read id", v, IDV);
    xfer(A_ID, 32'h0, O_CLR, 1'b1, P_M, ill, v);
    chk("R8 clear zero operand legal", {31'd0, ill}, 32'd0);
    xfer(A_ID, 32'h0000_0001, O_CLR, 1'b1, P_M, ill, v);
    chk("R8 clear nonzero illegal", {31'd0, ill}, 32'd1);
    rd_reg(A_ID, v); chk("R8 id unchanged", v, IDV);
  endtask

  task automatic t_ctrl_mask;
    logic ill; logic [31:0] v;
    xfer(A_C, 32'hFFFF_FFFF, O_SWAP, 1'b1, P_M, ill, v);
    rd_reg(A_C, v); chk("R9 writable bits only", v, CWM);
    xfer(A_C, 32'h0000_0F00, O_CLR, 1'b1, P_M, ill, v);
    rd_reg(A_C, v); chk("R9 after clear", v, 32'h0000_000F);
  endtask

  task automatic t_bad_op;
    logic ill; logic [31:0] v;
    xfer(A_M, 32'hFFFF_FFFF, O_NONE, 1'b1, P_M, ill, v);
    chk("R10 illegal", {31'd0, ill}, 32'd1);
    chk("R10 zero data", v, 32'd0);
    rd_reg(A_M, v); chk("R10 no change", v, 32'h1234_5678);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_swap;
    t_set;
    t_clr;
    t_back2back;
    t_bad_addr;
    t_priv;
    t_ro;
    t_ctrl_mask;
    t_bad_op;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run;
  end

endmodule